// File: doc/BRIEF.md
# Opcode-Selected 32-Bit Arithmetic Logic Unit

This block is the integer execution unit of a datapath. It takes two operands, one carry/borrow bit and a 4-bit operation code, and returns a result one bit wider than the operands. The extra top bit holds the carry out of an addition, or the no-borrow indication of a subtraction. For the logic and shift operations that top bit is zero.

Three sub-units feed one selector driven by the operation code. The first is a ripple-carry add/subtract chain built from one-bit full adders. The second is a logic unit that forms every function from four primitive gates (AND, OR, XOR and NOT). The third is a clocked shift register. Its capture and shift controls are decoded from the operation code. On any cycle with a non-shift code, the register takes in operand A. On each clock while a shift code is held, it moves one position.

The arithmetic and logic paths are combinational, so their result is valid in the same cycle. The shift result evolves one step per clock. It starts from the operand A that was present on the last cycle before the shift code arrived. Synchronous reset acts only on the shift register.

Top module: `opsel_alu`

## Requirements
- R1: The operation codes are 0 NOT, 1 AND, 2 OR, 3 NAND, 4 NOR, 5 XOR, 6 XNOR, 7 shift left, 8 shift right, 9 add, 10 subtract.
- R2: Codes 11 to 15 drive all 33 result bits to zero.
- R3: Code 9 gives result = A + B + cb_in, with bit 32 equal to the carry out of bit 31.
- R4: Code 10 gives A + ~B + (1 - cb_in), so cb_in acts as a borrow-in. Result bit 32 is 1 exactly when no borrow leaves bit 31.
- R5: Codes 0, 1, 2 and 5 give ~A, A&B, A|B and A^B in bits 31:0. Operand B has no effect on code 0, and bit 32 is zero.
- R6: Codes 3, 4 and 6 give the bitwise inverse of AND, OR and XOR respectively, with bit 32 zero.
- R7: On every clock edge with a non-shift code, the shift register captures operand A. On the first cycle of a shift code, bits 31:0 of the result equal that captured A.
- R8: While code 7 is held, each clock moves the register one position toward the MSB and fills bit 0 with zero. The result shows it in bits 31:0, with bit 32 zero.
- R9: While code 8 is held, each clock moves the register one position toward the LSB and fills bit 31 with zero. The result shows it in bits 31:0, with bit 32 zero.
- R10: Synchronous reset clears the shift register, so a shift code then reads zero. It does not change the combinational add/subtract/logic result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the shift register |
| opnd_a | input | 32 | First operand; also the shift register load value |
| opnd_b | input | 32 | Second operand |
| cb_in | input | 1 | Carry-in for add, borrow-in for subtract |
| op_code | input | 4 | Operation select |
| result | output | 33 | Selected result; bit 32 is carry / no-borrow |

## Verification
The bench builds the block with its default width of 32. At this width the all-ones carry chain, zero minus one, and equal-operand subtraction can be driven directly. A full 32-step shift sequence also fits in a short run, so it reaches the point where every original bit has left the register and the output settles to zero. Random operand sweeps cover every combinational operation code, including the unused ones. These sweeps are compared against a bench-side arithmetic model.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOT  = 4'd0,
        OP_AND  = 4'd1,
        OP_OR   = 4'd2,
        OP_NAND = 4'd3,
        OP_NOR  = 4'd4,
        OP_XOR  = 4'd5,
        OP_XNOR = 4'd6,
        OP_SHL  = 4'd7,
        OP_SHR  = 4'd8,
        OP_ADD  = 4'd9,
        OP_SUB  = 4'd10
    } alu_op_e;

    typedef struct packed {
        logic load;      // capture operand A this edge
        logic shift_en;  // move register one position this edge
        logic to_msb;    // direction of movement
    } shift_ctl_t;

    function automatic shift_ctl_t decode_shift(input logic [OP_W-1:0] op);
        shift_ctl_t c;
        c.shift_en = (op == OP_SHL) || (op == OP_SHR);
        c.load     = !c.shift_en;
        c.to_msb   = (op == OP_SHL);
        return c;
    endfunction

    function automatic logic is_logic_op(input logic [OP_W-1:0] op);
        return op <= OP_XNOR;
    endfunction

endpackage

// File: rtl/rc_addsub.sv
module rc_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cb,
    input  logic         subtract,
    output logic [W:0]   sum
);
    logic [W-1:0] b_eff;
    logic [W-1:0] s;
    logic [W:0]   c;

    assign b_eff = subtract ? ~b : b;
    assign c[0]  = subtract ? ~cb : cb;

    for (genvar i = 0; i < W; i++) begin : g_fa
        logic p;
        assign p        = a[i] ^ b_eff[i];
        assign s[i]     = p ^ c[i];
        assign c[i+1]   = (a[i] & b_eff[i]) | (p & c[i]);
    end

    assign sum = {c[W], s};
endmodule

// File: rtl/gate_logic.sv
module gate_logic
    import opsel_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [OP_W-1:0] op,
    output logic [W-1:0]    y
);
    logic [W-1:0] g_and, g_or, g_xor, g_not;

    assign g_and = a & b;
    assign g_or  = a | b;
    assign g_xor = a ^ b;
    assign g_not = ~a;

    always_comb begin
        case (op)
            OP_NOT:  y = g_not;
            OP_AND:  y = g_and;
            OP_OR:   y = g_or;
            OP_NAND: y = ~g_and;
            OP_NOR:  y = ~g_or;
            OP_XOR:  y = g_xor;
            OP_XNOR: y = ~g_xor;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/seq_shifter.sv
module seq_shifter
    import opsel_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  shift_ctl_t   ctl,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (ctl.load) begin
            q <= din;
        end else if (ctl.shift_en) begin
            if (ctl.to_msb) q <= {q[W-2:0], 1'b0};
            else            q <= {1'b0, q[W-1:1]};
        end
    end
endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
    import opsel_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [W-1:0]    opnd_a,
    input  logic [W-1:0]    opnd_b,
    input  logic            cb_in,
    input  logic [OP_W-1:0] op_code,
    output logic [W:0]      result
);
    shift_ctl_t   sh_ctl;
    logic [W:0]   arith_y;
    logic [W-1:0] logic_y;
    logic [W-1:0] shift_q;

    assign sh_ctl = decode_shift(op_code);

    rc_addsub #(.W(W)) u_arith (
        .a        (opnd_a),
        .b        (opnd_b),
        .cb       (cb_in),
        .subtract (op_code == OP_SUB),
        .sum      (arith_y)
    );

    gate_logic #(.W(W)) u_logic (
        .a  (opnd_a),
        .b  (opnd_b),
        .op (op_code),
        .y  (logic_y)
    );

    seq_shifter #(.W(W)) u_shift (
        .clk (clk),
        .rst (rst),
        .din (opnd_a),
        .ctl (sh_ctl),
        .q   (shift_q)
    );

    always_comb begin
        if (is_logic_op(op_code))
            result = {1'b0, logic_y};
        else if (sh_ctl.shift_en)
            result = {1'b0, shift_q};
        else if (op_code == OP_ADD || op_code == OP_SUB)
            result = arith_y;
        else
            result = '0;
    end
endmodule

// File: rtl/opsel_alu_chk.sv
module opsel_alu_chk
    import opsel_alu_pkg::*;
#(
    parameter int W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [W-1:0]    opnd_a,
    input logic [W-1:0]    opnd_b,
    input logic            cb_in,
    input logic [OP_W-1:0] op_code,
    input logic [W:0]      result
);
    // R2: unused codes give zero
    a_r2_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (op_code > OP_SUB) |-> (result == '0));

    // R3: addition matches a wide sum
    a_r3_add_sum: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_ADD) |->
        (result == ({1'b0, opnd_a} + {1'b0, opnd_b} + {{W{1'b0}}, cb_in})));

    // R5 / R6: logic codes never set the top bit
    a_r5_logic_top_clear: assert property (@(posedge clk) disable iff (rst)
        (op_code <= OP_XNOR) |-> (result[W] == 1'b0));

    // R7: first shift cycle shows the operand captured one edge earlier
    a_r7_load_capture: assert property (@(posedge clk) disable iff (rst)
        ((op_code == OP_SHL || op_code == OP_SHR) && !$past(rst)
         && $past(op_code) != OP_SHL && $past(op_code) != OP_SHR)
        |-> (result == {1'b0, $past(opnd_a)}));

    // R8: left movement, zero fill
    a_r8_shift_left: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_SHL && $past(op_code) == OP_SHL && !$past(rst))
        |-> (result == {1'b0, $past(result[W-2:0]), 1'b0}));

    // R9: right movement, zero fill
    a_r9_shift_right: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_SHR && $past(op_code) == OP_SHR && !$past(rst))
        |-> (result == {2'b00, $past(result[W-1:1])}));

    // R10: a shift code after a reset edge reads zero
    a_r10_reset_clears: assert property (@(posedge clk)
        ($past(rst) && (op_code == OP_SHL || op_code == OP_SHR)
         && ($past(op_code) == OP_SHL || $past(op_code) == OP_SHR))
        |-> (result == '0));
endmodule

bind opsel_alu opsel_alu_chk #(.W(W)) u_chk (.*);

// File: tb/opsel_alu_test.sv
module opsel_alu_test;
    localparam int W = 32;
    localparam int VW = 4 + W + W + 1 + (W + 1);
    localparam int NV = 14;

    // {op, a, b, cb, expected}
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd0,  32'hF0F0_0000, 32'h1234_5678, 1'b1, 33'h0_0F0F_FFFF},
        {4'd1,  32'hFF00_FF00, 32'h0FF0_0FF0, 1'b1, 33'h0_0F00_0F00},
        {4'd2,  32'hFF00_FF00, 32'h0FF0_0FF0, 1'b0, 33'h0_FFF0_FFF0},
        {4'd3,  32'hFF00_FF00, 32'h0FF0_0FF0, 1'b0, 33'h0_F0FF_F0FF},
        {4'd4,  32'hFF00_FF00, 32'h0FF0_0FF0, 1'b1, 33'h0_000F_000F},
        {4'd5,  32'hFF00_FF00, 32'h0FF0_0FF0, 1'b0, 33'h0_F0F0_F0F0},
        {4'd6,  32'hFF00_FF00, 32'h0FF0_0FF0, 1'b1, 33'h0_0F0F_0F0F},
        {4'd9,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 33'h1_FFFF_FFFF},
        {4'd9,  32'h0000_0007, 32'h0000_0008, 1'b0, 33'h0_0000_000F},
        {4'd10, 32'h0000_0000, 32'h0000_0001, 1'b0, 33'h0_FFFF_FFFF},
        {4'd10, 32'h0000_0005, 32'h0000_0003, 1'b1, 33'h1_0000_0001},
        {4'd10, 32'h0000_0005, 32'h0000_0005, 1'b0, 33'h1_0000_0000},
        {4'd11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 33'h0_0000_0000},
        {4'd15, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 33'h0_0000_0000}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         cb_in = 1'b0;
    logic [3:0]   op_code = 4'd7;
    logic [W:0]   result;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    opsel_alu #(.W(W)) uut (
        .clk     (clk),
        .rst     (rst),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .cb_in   (cb_in),
        .op_code (op_code),
        .result  (result)
    );

    task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s op=%0d act=%h exp=%h", req, op_code, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic cb);
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b; cb_in = cb;
        #1;
    endtask

    function automatic string tag_of(input logic [3:0] op);
        if (op == 4'd0 || op == 4'd1 || op == 4'd2 || op == 4'd5) return "R1 R5";
        if (op == 4'd3 || op == 4'd4 || op == 4'd6) return "R1 R6";
        if (op == 4'd9)  return "R1 R3";
        if (op == 4'd10) return "R1 R4";
        return "R2";
    endfunction

    function automatic logic [W:0] model(input logic [3:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic cb);
        case (op)
            4'd0:  return {1'b0, ~a};
            4'd1:  return {1'b0, a & b};
            4'd2:  return {1'b0, a | b};
            4'd3:  return {1'b0, ~(a & b)};
            4'd4:  return {1'b0, ~(a | b)};
            4'd5:  return {1'b0, a ^ b};
            4'd6:  return {1'b0, ~(a ^ b)};
            4'd9:  return {1'b0, a} + {1'b0, b} + (W+1)'(cb);
            4'd10: return {1'b0, a} + {1'b0, ~b} + (W+1)'(!cb);
            default: return '0;
        endcase
    endfunction

    task automatic shift_run(input logic [3:0] op, input logic [W-1:0] seed, input string req);
        logic [W-1:0] exp;
        drive(4'd1, seed, 32'h0, 1'b0);          // load cycle (R7)
        drive(op, 32'hDEAD_BEEF, 32'h0, 1'b1);   // A changes: must not matter
        chk("R7", result, {1'b0, seed});
        exp = seed;
        for (int k = 1; k <= W; k++) begin
            @(negedge clk); #1;
            exp = (op == 4'd7) ? (exp << 1) : (exp >> 1);
            chk(req, result, {1'b0, exp});
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R10: reset with a shift code held clears the register
        opnd_a = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R10 reset state", result, '0);
        op_code = 4'd9; opnd_b = 32'h1; cb_in = 1'b0; #1;
        chk("R10 add during reset", result, 33'h1_0000_0000);
        op_code = 4'd7; #1;
        @(negedge clk); rst = 1'b0; #1;
        @(negedge clk); #1;
        chk("R10 zero after release", result, '0);

        // Table walk: R1..R6
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][VW-1 -: 4], VEC[i][VW-5 -: W], VEC[i][VW-5-W -: W],
                  VEC[i][W+1]);
            chk(tag_of(op_code), result, VEC[i][W:0]);
        end

        // Random sweep over combinational codes
        for (int i = 0; i < 60; i++) begin
            logic [3:0] op;
            logic [W-1:0] a, b;
            logic cb;
            op = 4'($urandom_range(0, 15));
            if (op == 4'd7 || op == 4'd8) op = 4'd9;
            a = $urandom; b = $urandom; cb = 1'($urandom);
            if (i % 7 == 0) b = a;
            drive(op, a, b, cb);
            chk(tag_of(op), result, model(op, a, b, cb));
        end

        // Shift sequences
        shift_run(4'd7, 32'h8000_0001, "R8");
        shift_run(4'd8, 32'h8000_0001, "R9");
        shift_run(4'd7, 32'h1234_5679, "R8");

        // R10: reset mid-shift
        drive(4'd5, 32'hA5A5_A5A5, 32'h0, 1'b0);
        drive(4'd8, 32'h0, 32'h0, 1'b0);
        chk("R7", result, 33'h0_A5A5_A5A5);
        rst = 1'b1;
        @(negedge clk); #1;
        chk("R10 mid-shift reset", result, '0);
        op_code = 4'd10; opnd_a = 32'h0; opnd_b = 32'h1; cb_in = 1'b0; #1;
        chk("R10 sub during reset", result, 33'h0_FFFF_FFFF);
        @(negedge clk); rst = 1'b0; #1;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule